// File: doc/BRIEF.md
# Mailbox Ring Completion Engine

This block is the adapter side of a two-ring mailbox scheme kept in a small on-chip byte memory. The region starts at a programmable base. It holds a request ring of N entries, and directly behind it a reply ring of N entries. The host fills request entries and then sends a one-byte scan command. The engine walks the request ring from its own position. It takes every occupied entry, hands the slot back by zeroing its code byte, and queues the job.

A fixed-latency model stands in for job execution. When a job matures, the engine writes a reply entry at its own reply position. It waits if the host has not yet emptied that slot, and it raises the loaded interrupt. Two entry formats are supported: a 4-byte entry with a 24-bit pointer and an 8-byte entry with a 32-bit pointer and two status bytes. The format is chosen by the configuration opcode. The host reaches the memory through a plain byte port and uses it both to build requests and to consume replies.

Top module: `mbx_ring_engine`

## Requirements
- R1: After reset the interrupt output is 0 and the engine is unconfigured: a scan command (0x02) leaves the memory untouched.
- R2: The configuration sequences on the command byte stream are as follows. Opcode 0x01 is followed by a count byte and a 3-byte base address, most significant byte first, and selects the 4-byte format. Opcode 0x81 is followed by a count byte and a 4-byte base, least significant byte first, and selects the 8-byte format. Either sequence sets the request index to 0 and the reply index to N.
- R3: A configuration whose count is 0, is not a multiple of 8, or exceeds MAX_RING is discarded, and the previous configuration and indices stay in force.
- R4: On a scan command the engine takes request entries from its request index onward until it meets a code of 0x00. It zeroes the code of each entry it takes. The request index wraps from N-1 to 0.
- R5: Reply codes are assigned per job. A request code of 0x02 yields reply code 0x03. Any other nonzero request code yields 0x01 when pointer bit 0 is 0 and 0x04 when it is 1. Replies appear no earlier than LATENCY cycles after pickup and in pickup order.
- R6: The 4-byte format places the code in byte 0 and the 24-bit pointer in bytes 1 to 3, most significant byte first.
- R7: The 8-byte format places the 32-bit pointer in bytes 0 to 3, least significant byte first. Byte 4 is adapter status (0x00), byte 5 is device status (0x02 for a reply of code 0x04, otherwise 0x00), byte 6 is 0x00 and byte 7 is the code.
- R8: The reply index runs from N to 2N-1 and then wraps to N.
- R9: A reply is written only into a slot whose code is 0x00. Otherwise it waits, and the occupied slot keeps its contents.
- R10: Each reply write sets the interrupt output. It stays set until irqClear is asserted, and a write in the same cycle wins over the clear.
- R11: Every reply carries the same pointer value that was read from its request entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command byte strobe |
| cmdData | input | 8 | Command or parameter byte |
| hostWrEn | input | 1 | Host memory byte write |
| hostAddr | input | AW | Host memory byte address |
| hostWrData | input | 8 | Host write byte |
| hostRdData | output | 8 | Byte at hostAddr, one cycle later |
| irqClear | input | 1 | Clears the loaded interrupt |
| irqMbLoaded | output | 1 | Reply-loaded interrupt |

## Verification
The assertions take for granted that the command stream is well formed. They also assume the host touches a request entry only when the engine has not yet reached it, and a reply entry only after the engine wrote it or before the ring was configured. The bench keeps to this. It writes all request entries before sending a scan command. It clears only reply slots it has already consumed, except for one deliberately occupied slot that it seeds while the engine is idle. It sends configuration bytes only when no jobs are pending.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef struct packed {
    logic loadCfg;
    logic pushJob;
    logic clearOut;
    logic writeIn;
  } mbx_strobe_t;

  localparam logic [7:0] CODE_FREE    = 8'h00;
  localparam logic [7:0] REQ_ABORT    = 8'h02;
  localparam logic [7:0] RPL_OK       = 8'h01;
  localparam logic [7:0] RPL_NOTFOUND = 8'h03;
  localparam logic [7:0] RPL_ERROR    = 8'h04;
  localparam logic [7:0] DEV_CHECK    = 8'h02;
  localparam logic [7:0] OP_CFG_SHORT = 8'h01;
  localparam logic [7:0] OP_CFG_LONG  = 8'h81;
  localparam logic [7:0] OP_SCAN      = 8'h02;
endpackage

// File: rtl/mbx_datapath.sv
module mbx_datapath
  import mbx_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int MAX_RING  = 64,
  parameter int QDEPTH    = 4,
  parameter int LATENCY   = 16,
  parameter int STAMP_W   = 16,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int IW = $clog2(2 * MAX_RING) + 1
) (
  input  logic           clk,
  input  logic           rstN,
  input  mbx_strobe_t    stb,
  input  logic [7:0]     cfgCount,
  input  logic [AW-1:0]  cfgBase,
  input  logic           cfgLong,
  input  logic           hostWrEn,
  input  logic [AW-1:0]  hostAddr,
  input  logic [7:0]     hostWrData,
  output logic [7:0]     hostRdData,
  input  logic           irqClear,
  output logic           irqMbLoaded,
  output logic           configured,
  output logic [7:0]     outCode,
  output logic           fifoFull,
  output logic           headReady,
  output logic           inSlotFree
);
  localparam int QW = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;

  logic [7:0]    mem [MEM_BYTES];
  logic [IW-1:0] ringN, outIdx, inIdx, inLast;
  logic [AW-1:0] baseAddr, outAddr, inAddr, wrAddr;
  logic          longMode;
  logic [7:0]    outByte [8];
  logic [7:0]    inByte  [8];
  logic [7:0]    wrByte  [8];
  logic [7:0]    wrEn;
  logic [31:0]   outPtr;
  logic [7:0]    inCode;

  logic [31:0]        qPtr   [QDEPTH];
  logic               qAbort [QDEPTH];
  logic [STAMP_W-1:0] qStamp [QDEPTH];
  logic [QW-1:0]      wrPtr, rdPtr;
  logic [QW:0]        qCount;
  logic [STAMP_W-1:0] now;

  logic [31:0] headPtr;
  logic        headAbort;
  logic [7:0]  rplCode, devStat;

  assign configured = (ringN != '0);
  assign inLast     = IW'({ringN, 1'b0} - 1'b1);
  assign outAddr    = baseAddr + (longMode ? AW'({outIdx, 3'b000}) : AW'({outIdx, 2'b00}));
  assign inAddr     = baseAddr + (longMode ? AW'({inIdx, 3'b000})  : AW'({inIdx, 2'b00}));

  always_comb begin
    for (int k = 0; k < 8; k++) begin
      outByte[k] = mem[outAddr + AW'(k)];
      inByte[k]  = mem[inAddr + AW'(k)];
    end
  end

  assign outCode    = longMode ? outByte[7] : outByte[0];
  assign outPtr     = longMode ? {outByte[3], outByte[2], outByte[1], outByte[0]}
                               : {8'h00, outByte[1], outByte[2], outByte[3]};
  assign inCode     = longMode ? inByte[7] : inByte[0];
  assign inSlotFree = (inCode == CODE_FREE);

  // job queue
  assign fifoFull  = (qCount == (QW+1)'(QDEPTH));
  assign headPtr   = qPtr[rdPtr];
  assign headAbort = qAbort[rdPtr];
  assign headReady = (qCount != '0) &&
                     (STAMP_W'(now - qStamp[rdPtr]) >= STAMP_W'(LATENCY));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr  <= '0;
      rdPtr  <= '0;
      qCount <= '0;
      now    <= '0;
    end else begin
      now <= now + 1'b1;
      if (stb.loadCfg) begin
        wrPtr  <= '0;
        rdPtr  <= '0;
        qCount <= '0;
      end else begin
        if (stb.pushJob) begin
          qPtr[wrPtr]   <= outPtr;
          qAbort[wrPtr] <= (outCode == REQ_ABORT);
          qStamp[wrPtr] <= now;
          wrPtr         <= (wrPtr == QW'(QDEPTH - 1)) ? '0 : wrPtr + 1'b1;
        end
        if (stb.writeIn)
          rdPtr <= (rdPtr == QW'(QDEPTH - 1)) ? '0 : rdPtr + 1'b1;
        qCount <= qCount + (QW+1)'(stb.pushJob) - (QW+1)'(stb.writeIn);
      end
    end
  end

  // reply contents
  always_comb begin
    rplCode = headAbort ? RPL_NOTFOUND : (headPtr[0] ? RPL_ERROR : RPL_OK);
    devStat = (rplCode == RPL_ERROR) ? DEV_CHECK : 8'h00;
  end

  always_comb begin
    wrEn   = '0;
    wrAddr = outAddr;
    for (int k = 0; k < 8; k++) wrByte[k] = 8'h00;
    if (stb.clearOut) begin
      wrAddr = outAddr;
      if (longMode) wrEn[7] = 1'b1;
      else          wrEn[0] = 1'b1;
    end else if (stb.writeIn) begin
      wrAddr = inAddr;
      if (longMode) begin
        wrEn      = 8'hFF;
        wrByte[0] = headPtr[7:0];
        wrByte[1] = headPtr[15:8];
        wrByte[2] = headPtr[23:16];
        wrByte[3] = headPtr[31:24];
        wrByte[5] = devStat;
        wrByte[7] = rplCode;
      end else begin
        wrEn      = 8'h0F;
        wrByte[0] = rplCode;
        wrByte[1] = headPtr[23:16];
        wrByte[2] = headPtr[15:8];
        wrByte[3] = headPtr[7:0];
      end
    end
  end

  // shared memory: host write lands last
  always_ff @(posedge clk) begin
    for (int k = 0; k < 8; k++)
      if (wrEn[k]) mem[wrAddr + AW'(k)] <= wrByte[k];
    if (hostWrEn) mem[hostAddr] <= hostWrData;
    hostRdData <= mem[hostAddr];
  end

  // ring indices and interrupt
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ringN       <= '0;
      baseAddr    <= '0;
      longMode    <= 1'b0;
      outIdx      <= '0;
      inIdx       <= '0;
      irqMbLoaded <= 1'b0;
    end else begin
      if (stb.loadCfg) begin
        ringN    <= IW'(cfgCount);
        baseAddr <= cfgBase;
        longMode <= cfgLong;
        outIdx   <= '0;
        inIdx    <= IW'(cfgCount);
      end else begin
        if (stb.clearOut)
          outIdx <= (outIdx == ringN - 1'b1) ? '0 : outIdx + 1'b1;
        if (stb.writeIn)
          inIdx <= (inIdx == inLast) ? ringN : inIdx + 1'b1;
      end
      if (stb.writeIn)   irqMbLoaded <= 1'b1;
      else if (irqClear) irqMbLoaded <= 1'b0;
    end
  end

  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.pushJob |-> !fifoFull);
  assert_out_idx_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    configured |-> outIdx < ringN);
  assert_in_idx_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    configured |-> (inIdx >= ringN && inIdx <= inLast));
  assert_in_wrap_R8: assert property (@(posedge clk) disable iff (!rstN)
    (stb.writeIn && !stb.loadCfg && inIdx == inLast) |=> inIdx == ringN);
  assert_write_free_slot_R9: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeIn |-> (inCode == CODE_FREE && qCount != '0));
  assert_irq_on_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    stb.writeIn |=> irqMbLoaded);
  assert_cfg_count_valid_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadCfg |=> (ringN != '0 && ringN[2:0] == 3'b000));
endmodule

// File: rtl/mbx_control.sv
module mbx_control
  import mbx_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int MAX_RING  = 64,
  localparam int AW = $clog2(MEM_BYTES)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  input  logic [7:0]    cmdData,
  input  logic          configured,
  input  logic [7:0]    outCode,
  input  logic          fifoFull,
  input  logic          headReady,
  input  logic          inSlotFree,
  output mbx_strobe_t   stb,
  output logic [7:0]    cfgCount,
  output logic [AW-1:0] cfgBase,
  output logic          cfgLong
);
  typedef enum logic { P_OPCODE, P_ARGS } parse_e;

  parse_e      pState;
  logic [2:0]  argCnt, argLast;
  logic [7:0]  argByte [5];
  logic        initFire, scanReq, validCount;
  logic        scanning, rescan, scanEnd;
  logic [31:0] fullBase;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pState   <= P_OPCODE;
      argCnt   <= '0;
      argLast  <= '0;
      cfgLong  <= 1'b0;
      initFire <= 1'b0;
      scanReq  <= 1'b0;
      for (int k = 0; k < 5; k++) argByte[k] <= '0;
    end else begin
      initFire <= 1'b0;
      scanReq  <= 1'b0;
      if (cmdValid) begin
        if (pState == P_OPCODE) begin
          argCnt <= '0;
          if (cmdData == OP_CFG_SHORT) begin
            pState <= P_ARGS; argLast <= 3'd3; cfgLong <= 1'b0;
          end else if (cmdData == OP_CFG_LONG) begin
            pState <= P_ARGS; argLast <= 3'd4; cfgLong <= 1'b1;
          end else if (cmdData == OP_SCAN) begin
            scanReq <= 1'b1;
          end
        end else begin
          argByte[argCnt] <= cmdData;
          argCnt <= argCnt + 1'b1;
          if (argCnt == argLast) begin
            pState   <= P_OPCODE;
            initFire <= 1'b1;
          end
        end
      end
    end
  end

  assign cfgCount   = argByte[0];
  assign fullBase   = cfgLong ? {argByte[4], argByte[3], argByte[2], argByte[1]}
                              : {8'h00, argByte[1], argByte[2], argByte[3]};
  assign cfgBase    = fullBase[AW-1:0];
  assign validCount = (cfgCount != 8'h00) && (cfgCount[2:0] == 3'b000) &&
                      (int'(cfgCount) <= MAX_RING);

  always_comb begin
    stb = '0;
    stb.loadCfg = initFire && validCount;
    if (!stb.loadCfg && configured) begin
      if (headReady && inSlotFree) begin
        stb.writeIn = 1'b1;
      end else if (scanning && outCode != CODE_FREE && !fifoFull) begin
        stb.pushJob  = 1'b1;
        stb.clearOut = 1'b1;
      end
    end
  end

  assign scanEnd = scanning && !stb.writeIn && (outCode == CODE_FREE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      scanning <= 1'b0;
      rescan   <= 1'b0;
    end else if (stb.loadCfg) begin
      scanning <= 1'b0;
      rescan   <= 1'b0;
    end else if (scanEnd) begin
      scanning <= scanReq || rescan;
      rescan   <= 1'b0;
    end else if (scanReq && configured) begin
      if (scanning) rescan   <= 1'b1;
      else          scanning <= 1'b1;
    end
  end

  assert_take_only_when_scanning_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.pushJob |-> (scanning && configured));
  assert_unconfigured_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !configured |-> !scanning);
endmodule

// File: rtl/mbx_ring_engine.sv
module mbx_ring_engine
  import mbx_pkg::*;
#(
  parameter int MEM_BYTES = 1024,
  parameter int MAX_RING  = 64,
  parameter int QDEPTH    = 4,
  parameter int LATENCY   = 16,
  parameter int STAMP_W   = 16
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         cmdValid,
  input  logic [7:0]                   cmdData,
  input  logic                         hostWrEn,
  input  logic [$clog2(MEM_BYTES)-1:0] hostAddr,
  input  logic [7:0]                   hostWrData,
  output logic [7:0]                   hostRdData,
  input  logic                         irqClear,
  output logic                         irqMbLoaded
);
  localparam int AW = $clog2(MEM_BYTES);

  mbx_strobe_t   stb;
  logic [7:0]    cfgCount, outCode;
  logic [AW-1:0] cfgBase;
  logic          cfgLong, configured, fifoFull, headReady, inSlotFree;

  mbx_control #(.MEM_BYTES(MEM_BYTES), .MAX_RING(MAX_RING)) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdData(cmdData),
    .configured(configured), .outCode(outCode), .fifoFull(fifoFull),
    .headReady(headReady), .inSlotFree(inSlotFree), .stb(stb),
    .cfgCount(cfgCount), .cfgBase(cfgBase), .cfgLong(cfgLong)
  );

  mbx_datapath #(.MEM_BYTES(MEM_BYTES), .MAX_RING(MAX_RING), .QDEPTH(QDEPTH),
                 .LATENCY(LATENCY), .STAMP_W(STAMP_W)) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgCount(cfgCount), .cfgBase(cfgBase),
    .cfgLong(cfgLong), .hostWrEn(hostWrEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .irqClear(irqClear),
    .irqMbLoaded(irqMbLoaded), .configured(configured), .outCode(outCode),
    .fifoFull(fifoFull), .headReady(headReady), .inSlotFree(inSlotFree)
  );
endmodule

// File: tb/mbx_ring_engine_tb.sv
module mbx_ring_engine_tb_top;
  localparam int AW = 10;
  localparam int NR = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cmdValid = 1'b0;
  logic [7:0]    cmdData = '0;
  logic          hostWrEn = 1'b0;
  logic [AW-1:0] hostAddr = '0;
  logic [7:0]    hostWrData = '0;
  logic [7:0]    hostRdData;
  logic          irqClear = 1'b0;
  logic          irqMbLoaded;

  always #2.5 clk = ~clk;

  mbx_ring_engine dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdData(cmdData),
    .hostWrEn(hostWrEn), .hostAddr(hostAddr), .hostWrData(hostWrData),
    .hostRdData(hostRdData), .irqClear(irqClear), .irqMbLoaded(irqMbLoaded)
  );

  typedef struct { logic [31:0] ptr; logic [7:0] code; logic [7:0] dev; string req; } exp_t;
  exp_t expQ[$];

  int errors = 0, checks = 0;
  bit finished = 0;
  bit benchLong = 0;
  int base = 0;
  int expIn = NR;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic hwr(input int a, input logic [7:0] d);
    @(negedge clk); hostWrEn = 1'b1; hostAddr = AW'(a); hostWrData = d;
    @(negedge clk); hostWrEn = 1'b0;
  endtask

  task automatic hrd(input int a, output logic [7:0] d);
    @(negedge clk); hostAddr = AW'(a);
    @(negedge clk); d = hostRdData;
  endtask

  task automatic cmd(input logic [7:0] b);
    @(negedge clk); cmdValid = 1'b1; cmdData = b;
    @(negedge clk); cmdValid = 1'b0;
  endtask

  function automatic int slotAddr(input int idx);
    return base + idx * (benchLong ? 8 : 4);
  endfunction

  task automatic zeroRegion();
    for (int a = 0; a < 2 * NR * (benchLong ? 8 : 4); a++) hwr(base + a, 8'h00);
  endtask

  // driver: write a request entry and push its expected reply
  task automatic putReq(input int idx, input logic [7:0] code, input logic [31:0] ptr,
                        input string req);
    exp_t e;
    int a = slotAddr(idx);
    logic [31:0] p = benchLong ? ptr : {8'h00, ptr[23:0]};
    if (benchLong) begin
      hwr(a, p[7:0]); hwr(a+1, p[15:8]); hwr(a+2, p[23:16]); hwr(a+3, p[31:24]);
      hwr(a+7, code);
    end else begin
      hwr(a+1, p[23:16]); hwr(a+2, p[15:8]); hwr(a+3, p[7:0]); hwr(a, code);
    end
    e.ptr  = p;
    e.code = (code == 8'h02) ? 8'h03 : (p[0] ? 8'h04 : 8'h01);
    e.dev  = (e.code == 8'h04) ? 8'h02 : 8'h00;
    e.req  = req;
    expQ.push_back(e);
  endtask

  task automatic readCode(input int idx, output logic [7:0] c);
    hrd(slotAddr(idx) + (benchLong ? 7 : 0), c);
  endtask

  // monitor: pop expected replies and compare with the reply ring
  task automatic drain();
    logic [7:0] b [8];
    logic [7:0] c;
    while (expQ.size() != 0) begin
      exp_t e = expQ.pop_front();
      int a = slotAddr(expIn);
      c = 8'h00;
      for (int t = 0; t < 400 && c == 8'h00; t++) readCode(expIn, c);
      for (int k = 0; k < (benchLong ? 8 : 4); k++) hrd(a + k, b[k]);
      if (benchLong) begin
        check(b[7] == e.code, {e.req, " R5 R7 code byte7"}, b[7], e.code);
        check({b[3], b[2], b[1], b[0]} == e.ptr, {e.req, " R7 R11 pointer LSB first"},
              {b[3], b[2], b[1], b[0]}, e.ptr);
        check(b[4] == 8'h00 && b[6] == 8'h00, {e.req, " R7 status/pad"}, {b[4], b[6]}, 16'h0);
        check(b[5] == e.dev, {e.req, " R7 device status"}, b[5], e.dev);
        hwr(a + 7, 8'h00);
      end else begin
        check(b[0] == e.code, {e.req, " R5 R6 code byte0"}, b[0], e.code);
        check({8'h00, b[1], b[2], b[3]} == e.ptr, {e.req, " R6 R11 pointer MSB first"},
              {b[1], b[2], b[3]}, e.ptr);
        hwr(a, 8'h00);
      end
      expIn = (expIn == 2 * NR - 1) ? NR : expIn + 1;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] c;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(irqMbLoaded == 1'b0, "R1 irq low after reset", irqMbLoaded, 0);

    // R1: scan ignored while unconfigured
    hwr(0, 8'h01);
    cmd(8'h02);
    repeat (40) @(negedge clk);
    hrd(0, c);
    check(c == 8'h01, "R1 unconfigured scan leaves entry", c, 8'h01);
    hwr(0, 8'h00);

    // R2: short configuration, base 0x40
    benchLong = 0; base = 'h40; expIn = NR;
    zeroRegion();
    cmd(8'h01); cmd(8'(NR)); cmd(8'h00); cmd(8'h00); cmd(8'h40);
    putReq(0, 8'h01, 32'h00123456, "R2 short ok");
    putReq(1, 8'h01, 32'h00ABCDE1, "R5 short error");
    putReq(2, 8'h02, 32'h0000BEEF, "R5 short abort");
    cmd(8'h02);
    drain();
    for (int i = 0; i < 3; i++) begin
      readCode(i, c);
      check(c == 8'h00, "R4 request code cleared", c, 0);
    end
    check(irqMbLoaded == 1'b1, "R10 irq set by reply", irqMbLoaded, 1);
    @(negedge clk); irqClear = 1'b1; @(negedge clk); irqClear = 1'b0;
    check(irqMbLoaded == 1'b0, "R10 irq cleared", irqMbLoaded, 0);

    // R4 R8: wrap of both rings, queue stalls on a burst of seven
    for (int i = 0; i < 7; i++)
      putReq((3 + i) % NR, 8'h01, 32'h00100000 + i * 32'h111 + (i % 2), "R8 wrap burst");
    cmd(8'h02);
    drain();
    putReq(2, 8'h01, 32'h00777770, "R4 after request wrap");
    cmd(8'h02);
    drain();
    check(expIn == 11, "R8 bench index", expIn, 11);

    // R9: occupied reply slot blocks the completion
    hwr(slotAddr(11), 8'h55);
    putReq(3, 8'h01, 32'h00444440, "R9 delayed reply");
    cmd(8'h02);
    repeat (100) @(negedge clk);
    readCode(11, c);
    check(c == 8'h55, "R9 occupied slot untouched", c, 8'h55);
    readCode(3, c);
    check(c == 8'h00, "R4 request taken while blocked", c, 0);
    hwr(slotAddr(11), 8'h00);
    drain();

    // R2 R7: long configuration, base 0x100 LSB first
    benchLong = 1; base = 'h100; expIn = NR;
    zeroRegion();
    cmd(8'h81); cmd(8'(NR)); cmd(8'h00); cmd(8'h01); cmd(8'h00); cmd(8'h00);
    putReq(0, 8'h01, 32'h89ABCDEF, "R7 long error");
    putReq(1, 8'h01, 32'h01020304, "R7 long ok");
    putReq(2, 8'h02, 32'hCAFEF00C, "R7 long abort");
    cmd(8'h02);
    drain();

    // R3: invalid counts are discarded, indices continue
    cmd(8'h81); cmd(8'd12); cmd(8'h00); cmd(8'h02); cmd(8'h00); cmd(8'h00);
    cmd(8'h01); cmd(8'd72); cmd(8'h00); cmd(8'h00); cmd(8'h40);
    putReq(3, 8'h05, 32'h00000010, "R3 config kept");
    cmd(8'h02);
    drain();
    check(expIn == 12, "R3 reply index continued", expIn, 12);
    readCode(3, c);
    check(c == 8'h00, "R3 request taken in long layout", c, 0);

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule